// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single programmable timer channel. An up-counter advances on a prescaled count clock while the start input is high. When the counter equals the compare register on a count tick, it returns to zero and a sticky match flag is raised; the period is therefore the compare value plus one counts. If the counter reaches all ones without a match, the next tick wraps it to zero and raises an overflow flag instead. The match flag drives the interrupt output when the routing field in the control word selects interrupt delivery.

Software reaches three registers through a simple read/write port: a 16-bit control/status word, the counter and the compare register. Counter writes are not applied at once. They are staged, a write-pending flag is raised, and the new value is loaded a fixed number of input clocks later, when the flag drops. Software polls that flag before relying on the counter.

A prescaler clock enable qualifies the input clock; the count-clock select picks one tick per 1, 8, 32 or 128 enabled input clocks.

Top module: `cmatch_timer`

## Requirements
- R1: After reset the control/status word reads 0, the counter reads 0, the compare register reads all ones and the interrupt output is low.
- R2: The control/status word (address 0) keeps writable fields at bit 8 (mode), bit 7 (output enable), bits 5:4 (routing) and bits 2:0 (count-clock select); bits 12:9, 6 and 3 read as 0, and writing 0 to the word clears every writable field.
- R3: The counter advances only on cycles where start and the prescaler enable are both high, once per 1, 8, 32 or 128 such cycles for select values 7, 4, 5 and 6; select values 0 to 3 stop counting, and the prescale phase restarts whenever start is low.
- R4: On a count tick with the counter equal to the compare register, the counter becomes 0 and bit 15 (match flag) becomes 1, so one period spans compare value plus one ticks.
- R5: On a count tick with the counter at all ones and not equal to the compare register, the counter becomes 0 and bit 14 (overflow flag) becomes 1.
- R6: A control write with bit 15 or bit 14 at 0 clears that flag, a 1 leaves it as it was, and a flag set by an event on the same clock edge as a clearing write stays set.
- R7: A counter write (address 1) sets bit 13 (write-pending) from the next cycle for WR_DELAY cycles (default 3); the counter keeps its old value meanwhile and takes the written value on the clock edge where bit 13 clears.
- R8: The interrupt output is high exactly while the match flag is 1 and the routing field equals 2; routing values 0, 1 and 3 hold it low.
- R9: With start low the counter and both event flags keep their values.
- R10: A compare write (address 2) is visible in a read on the next cycle and is used by the next count tick; address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Channel run enable |
| pre_en | input | 1 | Prescaler clock enable, qualifies input clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control/status, 1 counter, 2 compare |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result appears in the cycle after the edge that caused it: a tick, a compare write, a control write and the setting of the write-pending flag are all visible one clock after the triggering edge, while a counter write lands WR_DELAY edges later. Reads are combinational, so the bench drives inputs one nanosecond after a rising edge and samples rdata and irq at the following falling edge, where a behavioural model updated on the same rising edge holds the expected value. Directed sequences count edges explicitly (for example, a pending flag seen on two reads and the new count on the third) and are also compared against hand-computed constants, covering wrap, overflow, same-edge clear and prescale counts.

// File: rtl/cmatch_timer.sv
module cmatch_timer #(
  parameter int CW       = 32,
  parameter int WR_DELAY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pre_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int PW = 7;
  localparam int WW = $clog2(WR_DELAY + 1);

  logic [CW-1:0] cnt, cmp, stage;
  logic          match, ovf, pend;
  logic [WW-1:0] wcnt;
  logic          mode, oen;
  logic [1:0]    route;
  logic [2:0]    cks;
  logic [PW-1:0] pre, div_last;
  logic          tick, load, hit, wrap;
  logic          wr_ctl, wr_cnt, wr_cmp;
  logic [15:0]   csr;

  always_comb begin
    case (cks)
      3'd4:    div_last = PW'(7);
      3'd5:    div_last = PW'(31);
      3'd6:    div_last = PW'(127);
      default: div_last = '0;
    endcase
  end

  assign wr_ctl = wr_en && addr == 2'd0;
  assign wr_cnt = wr_en && addr == 2'd1;
  assign wr_cmp = wr_en && addr == 2'd2;

  assign tick = start && pre_en && cks[2] && (pre >= div_last);
  assign load = pend && wcnt == WW'(1);
  assign hit  = tick && !load && cnt == cmp;
  assign wrap = tick && !load && !hit && cnt == '1;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else if (!start) pre <= '0;
    else if (pre_en && cks[2]) pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= stage;
    else if (tick) cnt <= hit ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      wcnt  <= '0;
      stage <= '0;
    end else if (wr_cnt) begin
      pend  <= 1'b1;
      wcnt  <= WW'(WR_DELAY);
      stage <= wdata;
    end else if (load) begin
      pend  <= 1'b0;
    end else if (pend) begin
      wcnt  <= wcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp <= '1;
    else if (wr_cmp) cmp <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match <= 1'b0;
      ovf   <= 1'b0;
      mode  <= 1'b0;
      oen   <= 1'b0;
      route <= '0;
      cks   <= '0;
    end else begin
      match <= hit  | (match & ~(wr_ctl & ~wdata[15]));
      ovf   <= wrap | (ovf   & ~(wr_ctl & ~wdata[14]));
      if (wr_ctl) begin
        mode  <= wdata[8];
        oen   <= wdata[7];
        route <= wdata[5:4];
        cks   <= wdata[2:0];
      end
    end
  end

  assign csr = {match, ovf, pend, 4'b0, mode, oen, 1'b0, route, 1'b0, cks};

  always_comb begin
    case (addr)
      2'd0:    rdata = CW'(csr);
      2'd1:    rdata = cnt;
      2'd2:    rdata = cmp;
      default: rdata = '0;
    endcase
  end

  assign irq = match && route == 2'd2;
endmodule

// File: rtl/cmatch_timer_chk.sv
module cmatch_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [CW-1:0] wdata,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic          match,
  input logic          ovf,
  input logic          pend,
  input logic          tick,
  input logic          load
);
  a_r4_match_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == cmp) |=> (cnt == '0 && match));

  a_r5_ovf_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == '1 && cnt != cmp) |=> (cnt == '0 && ovf));

  a_r6_match_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !(wr_en && addr == 2'd0 && !wdata[15])) |=> match);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_en && addr == 2'd0 && !wdata[14])) |=> ovf);

  a_r7_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> pend);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd0)) |=> irq);

  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !pend) |=> $stable(cnt));
endmodule

bind cmatch_timer cmatch_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .cnt(cnt), .cmp(cmp), .match(match), .ovf(ovf),
  .pend(pend), .tick(tick), .load(load)
);

// File: tb/cmatch_timer_tb_top.sv
`timescale 1ns/1ps
module cmatch_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n, start, pre_en, wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [31:0] got;

  always #4 clk = ~clk;

  cmatch_timer #(.CW(32), .WR_DELAY(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_en(pre_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_cmp, m_stage;
  bit m_match, m_ovf, m_pend, m_mode, m_oen;
  bit [1:0] m_route;
  bit [2:0] m_cks;
  int m_pre, m_left, dv;
  bit t, ld, sm, so;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_stage = 0;
      m_match = 0; m_ovf = 0; m_pend = 0; m_mode = 0; m_oen = 0;
      m_route = 0; m_cks = 0; m_pre = 0; m_left = 0;
    end else begin
      case (m_cks)
        3'd4: dv = 8;
        3'd5: dv = 32;
        3'd6: dv = 128;
        3'd7: dv = 1;
        default: dv = 0;
      endcase
      t = 0; sm = 0; so = 0;
      if (!start) m_pre = 0;
      else if (pre_en && dv != 0) begin
        if (m_pre + 1 >= dv) begin t = 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
      ld = m_pend && m_left == 1;
      if (ld) m_cnt = m_stage;
      else if (t) begin
        if (m_cnt == m_cmp) begin m_cnt = 0; sm = 1; end
        else if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = 0; so = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (wr_en && addr == 2'd0) begin
        if (!wdata[15]) m_match = 0;
        if (!wdata[14]) m_ovf = 0;
        m_mode = wdata[8]; m_oen = wdata[7];
        m_route = wdata[5:4]; m_cks = wdata[2:0];
      end
      if (sm) m_match = 1;
      if (so) m_ovf = 1;
      if (wr_en && addr == 2'd2) m_cmp = wdata;
      if (wr_en && addr == 2'd1) begin m_pend = 1; m_left = 3; m_stage = wdata; end
      else if (ld) m_pend = 0;
      else if (m_pend) m_left = m_left - 1;
    end
  end

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_match, m_ovf, m_pend, 4'b0, m_mode, m_oen, 1'b0,
                    m_route, 1'b0, m_cks};
      2'd1: return m_cnt;
      2'd2: return m_cmp;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(addr == 2'd1 ? "R4 model counter" : addr == 2'd2 ? "R10 model compare"
          : "R2 model control", rdata, m_read(addr));
      chk("R8 model irq", {31'h0, irq},
          {31'h0, m_match && m_route == 2'd2});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic w(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic r(logic [1:0] a, output logic [31:0] v);
    addr = a;
    #3 v = rdata;
    step();
  endtask

  task automatic run(int n);
    start = 1'b1;
    repeat (n) step();
    start = 1'b0;
  endtask

  task automatic rchk(string tag, logic [1:0] a, logic [31:0] exp);
    logic [31:0] v;
    r(a, v);
    chk(tag, v, exp);
  endtask

  task automatic irq_chk(string tag, logic exp);
    #3 chk(tag, {31'h0, irq}, {31'h0, exp});
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pre_en = 1'b1; wr_en = 1'b0;
    addr = 2'd0; wdata = 32'h0;
    repeat (5) step();
    rst_n = 1'b1;

    // R1 reset state
    rchk("R1 control", 2'd0, 32'h0);
    rchk("R1 counter", 2'd1, 32'h0);
    rchk("R1 compare", 2'd2, 32'hFFFF_FFFF);
    irq_chk("R1 irq", 1'b0);
    rchk("R10 address 3", 2'd3, 32'h0);

    // R2 field layout
    w(2'd0, 32'hFFFF);
    rchk("R2 fields", 2'd0, 32'h01B7);
    w(2'd0, 32'h0);
    rchk("R2 write zero", 2'd0, 32'h0);

    // R7 delayed counter load
    w(2'd1, 32'h55);
    rchk("R7 pending set", 2'd0, 32'h2000);
    rchk("R7 count old", 2'd1, 32'h0);
    rchk("R7 still pending", 2'd0, 32'h2000);
    rchk("R7 count loaded", 2'd1, 32'h55);
    rchk("R7 pending cleared", 2'd0, 32'h0);

    // R10 compare write
    w(2'd2, 32'h58);
    rchk("R10 compare", 2'd2, 32'h58);

    // R4 compare match
    w(2'd0, 32'h0027);
    run(3);
    rchk("R4 before match", 2'd1, 32'h58);
    rchk("R4 no flag yet", 2'd0, 32'h0027);
    run(1);
    rchk("R4 wrapped", 2'd1, 32'h0);
    rchk("R4 flag", 2'd0, 32'h8027);
    irq_chk("R8 irq on match", 1'b1);
    run(32'h59);
    rchk("R4 full period", 2'd1, 32'h0);
    run(2);

    // R9 stop holds
    repeat (20) step();
    rchk("R9 count held", 2'd1, 32'h2);
    rchk("R9 flag held", 2'd0, 32'h8027);

    // R6 flag clearing
    w(2'd0, 32'h8027);
    rchk("R6 write one keeps", 2'd0, 32'h8027);
    w(2'd0, 32'h0027);
    rchk("R6 write zero clears", 2'd0, 32'h0027);
    irq_chk("R8 irq low after clear", 1'b0);

    // R8 routing
    run(32'h57);
    irq_chk("R8 irq route 2", 1'b1);
    w(2'd0, 32'h8017);
    irq_chk("R8 route 1 no irq", 1'b0);
    rchk("R8 flag kept", 2'd0, 32'h8017);
    w(2'd0, 32'h8007);
    irq_chk("R8 route 0 no irq", 1'b0);
    w(2'd0, 32'h8027);
    irq_chk("R8 route 2 again", 1'b1);

    // R6 set beats clear on the same edge
    w(2'd1, 32'h58);
    repeat (3) step();
    start = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h0027;
    step();
    start = 1'b0; wr_en = 1'b0;
    rchk("R6 same edge set wins", 2'd0, 32'h8027);
    rchk("R6 same edge count", 2'd1, 32'h0);

    // R5 overflow
    w(2'd2, 32'h5);
    w(2'd0, 32'h0027);
    w(2'd1, 32'hFFFF_FFFE);
    repeat (3) step();
    run(2);
    rchk("R5 count wrapped", 2'd1, 32'h0);
    rchk("R5 overflow flag", 2'd0, 32'h4027);
    irq_chk("R8 overflow no irq", 1'b0);
    w(2'd0, 32'h0027);
    rchk("R6 overflow cleared", 2'd0, 32'h0027);

    // R3 prescaler
    w(2'd2, 32'h1000);
    w(2'd0, 32'h0024);
    run(16);
    rchk("R3 div8", 2'd1, 32'h2);
    run(15);
    rchk("R3 div8 phase restart", 2'd1, 32'h3);
    w(2'd0, 32'h0025);
    run(64);
    rchk("R3 div32", 2'd1, 32'h5);
    w(2'd0, 32'h0026);
    run(128);
    rchk("R3 div128", 2'd1, 32'h6);
    w(2'd0, 32'h0023);
    run(20);
    rchk("R3 select 3 stopped", 2'd1, 32'h6);
    w(2'd0, 32'h0027);
    pre_en = 1'b0;
    run(10);
    rchk("R3 enable low", 2'd1, 32'h6);
    pre_en = 1'b1;

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      pre_en = ($urandom % 4) != 0;
      start  = ($urandom % 10) < 8;
      addr   = 2'($urandom % 4);
      wr_en  = 1'b0;
      if ($urandom % 16 == 0) begin
        wr_en = 1'b1;
        addr  = 2'($urandom % 3);
        case (addr)
          2'd0: wdata = ($urandom & 32'hC1F7) | (($urandom % 5 != 0) ? 32'h4 : 32'h0);
          2'd1: wdata = ($urandom % 2) ? ($urandom % 40) : (32'hFFFF_FFF0 + $urandom % 16);
          default: wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom % 40);
        endcase
      end
      step();
    end
    wr_en = 1'b0; start = 1'b0;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule